// File: doc/BRIEF.md
# Next Instruction Word Address Selector

This block works out where a single-cycle processor fetches its next instruction. The program counter is held as a 30-bit word address, because instructions are word aligned and the two low byte-address bits are always zero. Each cycle the block receives the current word address, the 16-bit branch offset, the 26-bit jump field, the values of the two source registers, a 2-bit source select from the decoder and a 2-bit branch kind. It returns the chosen next word address. It also returns the current address plus one, which the register file stores as the return address of a jump-and-link.

The next address comes from one of four places. The first is the sequential or branch path: the address plus one, or that value plus the sign-extended offset when a conditional branch is taken. The second is a jump target built from the top four address bits and the 26-bit field. The third is the upper 30 bits of a register, used for a register jump. The fourth is a fixed operating-system entry address, used for a system call. The branch decision is made inside the block by comparing the register values directly. Both outputs are registered: the value for the inputs present at a rising clock edge appears just after that edge.

Top module: `nia_next_addr`

## Requirements
- R1: While `rst` is high at a rising edge, both `next_word` and `link_word` become zero after that edge.
- R2: With `pc_sel` = 00 and `br_kind` = 00 (no branch), `next_word` becomes `pc_word` + 1 modulo 2^30, so 30'h3FFFFFFF is followed by 0.
- R3: `link_word` always becomes `pc_word` + 1 modulo 2^30, whatever the select and branch kind.
- R4: A taken branch gives `pc_word` + 1 + the 16-bit offset sign-extended to 30 bits, modulo 2^30, with no overflow indication. Negative offsets move the address backwards.
- R5: `br_kind` = 01 is a branch that is taken exactly when bit 31 of `rs_val` is 1. When it is not taken, the result is `pc_word` + 1.
- R6: `br_kind` = 10 is taken exactly when `rs_val` equals `rt_val`. `br_kind` = 11 is taken exactly when they differ.
- R7: `pc_sel` = 01 gives `{pc_word[29:26], jump_field}`.
- R8: `pc_sel` = 10 gives `rs_val[31:2]`.
- R9: `pc_sel` = 11 gives the parameter `SYSCALL_WORD`, whose default value is 30'h0000_0100.
- R10: When `pc_sel` is not 00, `br_kind`, `imm16` and `rt_val` have no effect on `next_word`.
- R11: Every output reflects the inputs sampled at the preceding rising edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_word | input | 30 | Current instruction word address |
| imm16 | input | 16 | Branch offset in words, signed |
| jump_field | input | 26 | Jump target field of the instruction |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc_sel | input | 2 | 00 sequential/branch, 01 jump field, 10 register, 11 system entry |
| br_kind | input | 2 | 00 none, 01 less than zero, 10 equal, 11 not equal |
| next_word | output | 30 | Registered next instruction word address |
| link_word | output | 30 | Registered current address plus one |

## Verification
The sequential path is driven at the top of the address space to separate modulo-2^30 wrapping from plain increment. Branch offsets of both signs, including the most negative one, separate sign extension from zero extension. For each branch kind, register pairs are chosen both to meet and to miss the condition; this shows that the compare really decides the outcome and that only bit 31 matters for the less-than-zero test. Jump, register and system sources are driven with every branch kind and with equal operands. If `next_word` is unchanged across those cases, the branch logic is not leaking into the other sources. Random vectors biased towards equal operands then cover mixed sequences against a behavioural model on every clock.

// File: rtl/nia_pkg.sv
package nia_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_JUMP = 2'b01,
    SRC_REG  = 2'b10,
    SRC_SYS  = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_LTZ  = 2'b01,
    BR_EQ   = 2'b10,
    BR_NE   = 2'b11
  } br_kind_e;
endpackage

// File: rtl/nia_branch_cond.sv
module nia_branch_cond
  import nia_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  br_kind_e            kind,
  input  logic [DATA_W-1:0]   rs_val,
  input  logic [DATA_W-1:0]   rt_val,
  output logic                taken
);
  logic same;
  assign same = (rs_val == rt_val);

  always_comb begin
    unique case (kind)
      BR_LTZ:  taken = rs_val[DATA_W-1];
      BR_EQ:   taken = same;
      BR_NE:   taken = !same;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/nia_seq_path.sv
module nia_seq_path #(
  parameter int ADDR_W = 30,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] pc_word,
  input  logic [IMM_W-1:0]  imm,
  input  logic              taken,
  output logic [ADDR_W-1:0] inc_word,
  output logic [ADDR_W-1:0] seq_word
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] target;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offset = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign offset = imm[ADDR_W-1:0];
    end
  endgenerate

  assign inc_word = pc_word + ADDR_W'(1);
  assign target   = inc_word + offset;
  assign seq_word = taken ? target : inc_word;
endmodule

// File: rtl/nia_jump_form.sv
module nia_jump_form #(
  parameter int ADDR_W = 30,
  parameter int JTA_W  = 26
) (
  input  logic [ADDR_W-1:0] pc_word,
  input  logic [JTA_W-1:0]  field,
  output logic [ADDR_W-1:0] jump_word
);
  localparam int KEEP_W = ADDR_W - JTA_W;

  generate
    if (KEEP_W > 0) begin : g_region
      assign jump_word = {pc_word[ADDR_W-1 -: KEEP_W], field};
    end else begin : g_full
      assign jump_word = field[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/nia_next_addr.sv
module nia_next_addr
  import nia_pkg::*;
#(
  parameter int               ADDR_W       = 30,
  parameter int               IMM_W        = 16,
  parameter int               JTA_W        = 26,
  parameter int               DATA_W       = 32,
  parameter logic [ADDR_W-1:0] SYSCALL_WORD = 30'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_word,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JTA_W-1:0]  jump_field,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [1:0]        pc_sel,
  input  logic [1:0]        br_kind,
  output logic [ADDR_W-1:0] next_word,
  output logic [ADDR_W-1:0] link_word
);
  localparam int LOW_DROP = DATA_W - ADDR_W;

  src_sel_e          sel;
  logic              taken;
  logic [ADDR_W-1:0] inc_word, seq_word, jump_word, reg_word, pick;

  assign sel = src_sel_e'(pc_sel);

  nia_branch_cond #(.DATA_W(DATA_W)) u_cond (
    .kind   (br_kind_e'(br_kind)),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .taken  (taken)
  );

  nia_seq_path #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_seq (
    .pc_word  (pc_word),
    .imm      (imm16),
    .taken    (taken),
    .inc_word (inc_word),
    .seq_word (seq_word)
  );

  nia_jump_form #(.ADDR_W(ADDR_W), .JTA_W(JTA_W)) u_jump (
    .pc_word   (pc_word),
    .field     (jump_field),
    .jump_word (jump_word)
  );

  assign reg_word = rs_val[DATA_W-1 -: ADDR_W];

  always_comb begin
    unique case (sel)
      SRC_JUMP: pick = jump_word;
      SRC_REG:  pick = reg_word;
      SRC_SYS:  pick = SYSCALL_WORD;
      default:  pick = seq_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_word <= '0;
      link_word <= '0;
    end else begin
      next_word <= pick;
      link_word <= inc_word;
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (next_word == '0 && link_word == '0));

  p_default_r2: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b00 && br_kind == 2'b00) |=> next_word == ADDR_W'($past(pc_word) + ADDR_W'(1)));

  p_link_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> link_word == ADDR_W'($past(pc_word) + ADDR_W'(1)));

  p_ltz_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b00 && br_kind == 2'b01 && !rs_val[DATA_W-1])
      |=> next_word == ADDR_W'($past(pc_word) + ADDR_W'(1)));

  p_eq_skip_r6: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b00 && br_kind == 2'b10 && rs_val != rt_val)
      |=> next_word == ADDR_W'($past(pc_word) + ADDR_W'(1)));

  p_jump_r7: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b01) |=> next_word[JTA_W-1:0] == $past(jump_field));

  p_reg_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b10) |=> next_word == $past(rs_val[DATA_W-1:LOW_DROP]));

  p_sys_r9: assert property (@(posedge clk) disable iff (rst)
    (pc_sel == 2'b11) |=> next_word == SYSCALL_WORD);
endmodule

// File: tb/nia_next_addr_tb.sv
`timescale 1ns/1ps
module nia_next_addr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] pc_word = '0;
  logic [15:0] imm16 = '0;
  logic [25:0] jump_field = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [1:0]  pc_sel = '0;
  logic [1:0]  br_kind = '0;
  logic [29:0] next_word, link_word;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nia_next_addr u_dut (
    .clk(clk), .rst(rst), .pc_word(pc_word), .imm16(imm16),
    .jump_field(jump_field), .rs_val(rs_val), .rt_val(rt_val),
    .pc_sel(pc_sel), .br_kind(br_kind),
    .next_word(next_word), .link_word(link_word)
  );

  localparam longint MASK = 64'h3FFF_FFFF;

  function automatic logic [29:0] model_next(
      input logic [29:0] pc, input logic [15:0] imm, input logic [25:0] jf,
      input logic [31:0] rs, input logic [31:0] rt,
      input logic [1:0] sel, input logic [1:0] kind);
    longint step;
    bit go;
    step = longint'(pc) + 1;
    if (sel == 2'd1) return {pc[29:26], jf};
    if (sel == 2'd2) return rs >> 2;
    if (sel == 2'd3) return 30'h100;
    go = (kind == 2'd1 && rs[31]) || (kind == 2'd2 && rs == rt) ||
         (kind == 2'd3 && rs != rt);
    if (go) step = step + longint'($signed(imm));
    return 30'(step & MASK);
  endfunction

  task automatic check(input string tag, input logic [29:0] act, input logic [29:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [29:0] pc, input logic [15:0] imm,
                      input logic [25:0] jf, input logic [31:0] rs, input logic [31:0] rt,
                      input logic [1:0] sel, input logic [1:0] kind);
    logic [29:0] e_next, e_link;
    pc_word = pc; imm16 = imm; jump_field = jf; rs_val = rs; rt_val = rt;
    pc_sel = sel; br_kind = kind;
    e_next = model_next(pc, imm, jf, rs, rt, sel, kind);
    e_link = 30'((longint'(pc) + 1) & MASK);
    @(negedge clk);
    check({tag, " next R11"}, next_word, e_next);
    check("R3 link", link_word, e_link);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 reset next", next_word, 30'h0);
    check("R1 reset link", link_word, 30'h0);
    rst = 1'b0;

    step("R2 seq", 30'h0000_1000, 16'h7777, 26'h0, 32'h5, 32'h6, 2'd0, 2'd0);
    step("R2 wrap", 30'h3FFF_FFFF, 16'h0, 26'h0, 32'h0, 32'h0, 2'd0, 2'd0);
    step("R4 fwd", 30'h0000_0200, 16'h0010, 26'h0, 32'h7, 32'h7, 2'd0, 2'd2);
    step("R4 back", 30'h0000_0200, 16'hFFF0, 26'h0, 32'h7, 32'h7, 2'd0, 2'd2);
    step("R4 minneg wrap", 30'h0000_0003, 16'h8000, 26'h0, 32'h1, 32'h1, 2'd0, 2'd2);
    step("R4 top wrap", 30'h3FFF_FFF0, 16'h0100, 26'h0, 32'h1, 32'h2, 2'd0, 2'd3);
    step("R5 ltz taken", 30'h0000_0400, 16'h0020, 26'h0, 32'h8000_0000, 32'h0, 2'd0, 2'd1);
    step("R5 ltz not", 30'h0000_0400, 16'h0020, 26'h0, 32'h7FFF_FFFF, 32'h0, 2'd0, 2'd1);
    step("R6 eq not", 30'h0000_0400, 16'h0020, 26'h0, 32'h1234, 32'h1235, 2'd0, 2'd2);
    step("R6 ne taken", 30'h0000_0400, 16'h0020, 26'h0, 32'h1234, 32'h1235, 2'd0, 2'd3);
    step("R6 ne not", 30'h0000_0400, 16'h0020, 26'h0, 32'h1234, 32'h1234, 2'd0, 2'd3);
    step("R7 jump", 30'h2ABC_DEF0, 16'h0, 26'h155_5555, 32'h0, 32'h0, 2'd1, 2'd0);
    step("R8 reg", 30'h0000_0010, 16'h0, 26'h0, 32'hDEAD_BEEF, 32'h0, 2'd2, 2'd0);
    step("R9 sys", 30'h0123_4567, 16'h0, 26'h0, 32'h0, 32'h0, 2'd3, 2'd0);
    step("R10 jump eq", 30'h1000_0000, 16'h0004, 26'h000_0042, 32'h9, 32'h9, 2'd1, 2'd2);
    step("R10 reg ltz", 30'h1000_0000, 16'h0004, 26'h0, 32'hF000_0008, 32'h9, 2'd2, 2'd1);
    step("R10 sys ne", 30'h1000_0000, 16'h0004, 26'h0, 32'h1, 32'h9, 2'd3, 2'd3);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 2) == 0) ? a : $urandom;
      step("R4 rand", 30'($urandom), 16'($urandom), 26'($urandom), a, b,
           2'($urandom), 2'($urandom));
    end

    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset next", next_word, 30'h0);
    check("R1 mid reset link", link_word, 30'h0);
    rst = 1'b0;
    step("R2 after reset", 30'h0000_0007, 16'h0, 26'h0, 32'h0, 32'h0, 2'd0, 2'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule